// File: doc/BRIEF.md
# Exact Burst Beat Count Checker

This block watches a burst framing protocol and decides, for each burst, whether it carried exactly the required number of beats. A rising edge on the start line opens a burst. Counting begins on the following cycle. Beat pulses are counted as they arrive, with any number of idle cycles between them, and a pulse on the end line closes the burst. At that point the checker delivers a verdict. It gives either a one-cycle success pulse, or a one-cycle error pulse with a two-bit cause code.

A parameter selects one of two closing rules. In relaxed mode the end pulse may follow the final beat after any idle gap. In strict mode the end pulse must land on the cycle directly after the final beat. Some failures are reported as soon as they occur, without waiting for the end pulse: a surplus beat, or in strict mode a missed closing cycle. After any verdict the checker goes idle until the next rising edge of the start line.

All pins are plain control and status lines. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. Verdicts appear one cycle after the input cycle that decides them.

Top module: `burst_beat_checker`

## Requirements
- R1: A burst opens only on a rising edge of `burst_start` while idle. A beat in that same cycle, or while idle, is not counted. A `burst_end` while idle produces no output.
- R2: In relaxed mode (`TIGHT`=0), a burst of exactly `BEAT_COUNT` beats, with idle gaps anywhere including before `burst_end`, gives a one-cycle `burst_ok` in the cycle after `burst_end` is sampled.
- R3: A `burst_end` with fewer than `BEAT_COUNT` beats counted gives `err_pulse` with `err_cause` = 2'b01 in the next cycle.
- R4: A beat arriving when `BEAT_COUNT` beats are already counted gives `err_pulse` with `err_cause` = 2'b10 in the next cycle, without waiting for `burst_end`. The internal count never exceeds `BEAT_COUNT`.
- R5: In strict mode (`TIGHT`=1), `burst_end` on the cycle directly after the final beat gives `burst_ok`.
- R6: In strict mode, a cycle without `burst_end` after the final beat gives `err_pulse` with `err_cause` = 2'b11 in the following cycle.
- R7: A beat that coincides with `burst_end` is counted before the verdict. If that beat brings the total to `BEAT_COUNT`, relaxed mode reports success and strict mode reports cause 2'b11. If it pushes the total past `BEAT_COUNT`, both modes report cause 2'b10.
- R8: After any verdict the checker is idle. Further `burst_end` pulses are ignored. A `burst_start` held high does not reopen a burst; only a new rising edge does. A rising edge during an open burst is ignored.
- R9: While `rst_n` is low, all outputs are 0 and any open burst is discarded.
- R10: `err_pulse` and `burst_ok` are never high together. Each lasts one cycle. `err_cause` is 2'b00 whenever `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Opens a burst on its rising edge |
| beat | input | 1 | One beat per high cycle |
| burst_end | input | 1 | Closes the open burst |
| err_pulse | output | 1 | One-cycle error indication |
| err_cause | output | 2 | 01 too few, 10 too many, 11 strict-mode timing |
| burst_ok | output | 1 | One-cycle success indication |

## Verification
A relaxed and a strict instance receive the same stimulus, so every pattern shows whether the two closing rules diverge where they should. One pattern places a beat in the opening cycle and leaves an idle gap after the final beat. This separates a correct count start from an off-by-one, and it separates the relaxed rule from the strict one. Further patterns cover a short burst, a surplus beat, a beat that coincides with the end, and a surplus beat that coincides with the end; these tell the three cause codes and the coincident-beat rule apart. A start line held high, a rising edge during an open burst, and a reset in mid-burst show that only a fresh edge opens a burst and that reset discards state.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_SHORT = 2'b01,
    CAUSE_LONG  = 2'b10,
    CAUSE_LATE  = 2'b11
  } cause_t;

  typedef struct packed {
    logic   done;
    logic   ok;
    cause_t cause;
  } verdict_t;
endpackage

// File: rtl/bbc_start_edge.sv
module bbc_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/bbc_beat_tally.sv
module bbc_beat_tally #(
  parameter int BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           open_i,
  input  logic                           close_i,
  input  logic                           beat_i,
  output logic                           active_o,
  output logic [$clog2(BEATS+1)-1:0]     count_o
);
  localparam int CW = $clog2(BEATS + 1);

  logic          active_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (active_q) begin
      if (close_i) begin
        active_q <= 1'b0;
        count_q  <= '0;
      end else if (beat_i && (count_q < CW'(BEATS))) begin
        count_q <= count_q + CW'(1);
      end
    end else if (open_i) begin
      active_q <= 1'b1;
      count_q  <= '0;
    end
  end

  assign active_o = active_q;
  assign count_o  = count_q;

  // R4: the running total is bounded by the required count
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(BEATS));

  // R1: a burst becomes active only after an opening edge was seen
  assert_open_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(open_i));

  // R8: a verdict always returns the tally to idle
  assert_close_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && close_i) |=> !active_q);
endmodule

// File: rtl/bbc_verdict.sv
module bbc_verdict
  import bbc_pkg::*;
#(
  parameter int BEATS = 4,
  parameter bit TIGHT = 1'b0
) (
  input  logic                       active_i,
  input  logic [$clog2(BEATS+1)-1:0] count_i,
  input  logic                       beat_i,
  input  logic                       end_i,
  output verdict_t                   verdict_o
);
  localparam int CW = $clog2(BEATS + 1);

  logic [CW:0] total;
  logic        full;
  logic        surplus;
  logic        late_same;
  logic        late_gap;

  assign total   = {1'b0, count_i} + (CW+1)'(beat_i);
  assign full    = (count_i == CW'(BEATS));
  assign surplus = beat_i & full;

  generate
    if (TIGHT) begin : g_strict
      assign late_same = beat_i;
      assign late_gap  = full;
    end else begin : g_relaxed
      assign late_same = 1'b0;
      assign late_gap  = 1'b0;
    end
  endgenerate

  always_comb begin
    verdict_o = '{done: 1'b0, ok: 1'b0, cause: CAUSE_NONE};
    if (active_i) begin
      if (surplus) begin
        verdict_o.done  = 1'b1;
        verdict_o.cause = CAUSE_LONG;
      end else if (end_i) begin
        verdict_o.done = 1'b1;
        if (total < (CW+1)'(BEATS))
          verdict_o.cause = CAUSE_SHORT;
        else if (late_same)
          verdict_o.cause = CAUSE_LATE;
        else
          verdict_o.ok = 1'b1;
      end else if (late_gap) begin
        verdict_o.done  = 1'b1;
        verdict_o.cause = CAUSE_LATE;
      end
    end
  end
endmodule

// File: rtl/burst_beat_checker.sv
module burst_beat_checker
  import bbc_pkg::*;
#(
  parameter int BEAT_COUNT = 4,
  parameter bit TIGHT      = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_start,
  input  logic       beat,
  input  logic       burst_end,
  output logic       err_pulse,
  output logic [1:0] err_cause,
  output logic       burst_ok
);
  localparam int CW = $clog2(BEAT_COUNT + 1);

  logic          start_rise;
  logic          active;
  logic [CW-1:0] count;
  verdict_t      verdict;

  bbc_start_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (burst_start),
    .rise_o  (start_rise)
  );

  bbc_beat_tally #(.BEATS(BEAT_COUNT)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_i   (start_rise),
    .close_i  (verdict.done),
    .beat_i   (beat),
    .active_o (active),
    .count_o  (count)
  );

  bbc_verdict #(.BEATS(BEAT_COUNT), .TIGHT(TIGHT)) u_judge (
    .active_i  (active),
    .count_i   (count),
    .beat_i    (beat),
    .end_i     (burst_end),
    .verdict_o (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_cause <= 2'b00;
      burst_ok  <= 1'b0;
    end else begin
      err_pulse <= verdict.done & ~verdict.ok;
      err_cause <= verdict.cause;
      burst_ok  <= verdict.ok;
    end
  end

  // R10: success and error never coincide
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && burst_ok));

  // R10: each indication lasts exactly one cycle
  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse || burst_ok) |=> !(err_pulse || burst_ok));

  // R10: a cause is shown exactly when an error is shown
  assert_cause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_cause == 2'b00));
  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_cause != 2'b00));

  // R2: success only follows a sampled end pulse
  assert_ok_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ok |-> $past(burst_end));

  // R3: a short-burst error only follows a sampled end pulse
  assert_short_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && err_cause == 2'b01) |-> $past(burst_end));

  // R4: a surplus error only follows a sampled beat
  assert_long_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && err_cause == 2'b10) |-> $past(beat));
endmodule

// File: tb/burst_beat_checker_test.sv
`timescale 1ns/1ps
module burst_beat_checker_test;
  localparam int NONE  = 0;
  localparam int SHORT = 1;
  localparam int LONG  = 2;
  localparam int LATE  = 3;
  localparam int OK    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0;
  logic beat = 1'b0;
  logic burst_end = 1'b0;
  logic       err_l, ok_l, err_t, ok_t;
  logic [1:0] cause_l, cause_t;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_beat_checker #(.BEAT_COUNT(4), .TIGHT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .beat(beat),
    .burst_end(burst_end), .err_pulse(err_l), .err_cause(cause_l), .burst_ok(ok_l));

  burst_beat_checker #(.BEAT_COUNT(4), .TIGHT(1'b1)) uut_tight (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .beat(beat),
    .burst_end(burst_end), .err_pulse(err_t), .err_cause(cause_t), .burst_ok(ok_t));

  function automatic int observe(input logic e, input logic [1:0] c, input logic o);
    if (o && !e && c == 2'b00) return OK;
    if (e && !o && c != 2'b00) return int'(c);
    if (!e && !o && c == 2'b00) return NONE;
    return 7;
  endfunction

  task automatic judge(input string tag, input string which, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, which, got, want);
    end
  endtask

  // one cycle of stimulus; outputs are sampled after the edge that registers the verdict
  task automatic step(input logic s, input logic b, input logic e,
                      input int want_l, input int want_t, input string tag);
    @(negedge clk);
    burst_start = s; beat = b; burst_end = e;
    @(posedge clk);
    #1;
    judge(tag, "relaxed", observe(err_l, cause_l, ok_l), want_l);
    judge(tag, "strict",  observe(err_t, cause_t, ok_t), want_t);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; burst_start = 1'b0; beat = 1'b0; burst_end = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    judge("R9 reset", "relaxed", observe(err_l, cause_l, ok_l), NONE);
    judge("R9 reset", "strict",  observe(err_t, cause_t, ok_t), NONE);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_inputs();
    step(0, 0, 1, NONE, NONE, "R1 end while idle");
    step(0, 1, 0, NONE, NONE, "R1 beat while idle");
  endtask

  task automatic t_gap_before_end();
    step(1, 1, 0, NONE, NONE, "R1 beat in opening cycle");
    step(0, 1, 0, NONE, NONE, "R2 beat1");
    step(0, 0, 0, NONE, NONE, "R2 gap");
    step(0, 1, 0, NONE, NONE, "R2 beat2");
    step(0, 1, 0, NONE, NONE, "R2 beat3");
    step(0, 1, 0, NONE, NONE, "R2 beat4");
    step(0, 0, 0, NONE, LATE, "R6 idle after final beat");
    step(0, 0, 1, OK,   NONE, "R2 trailing end");
  endtask

  task automatic t_strict_exact();
    step(1, 0, 0, NONE, NONE, "R5 open");
    for (int i = 0; i < 4; i++) step(0, 1, 0, NONE, NONE, "R5 beat");
    step(0, 0, 1, OK, OK, "R5 end right after final beat");
  endtask

  task automatic t_short();
    step(1, 0, 0, NONE, NONE, "R3 open");
    step(0, 1, 0, NONE, NONE, "R3 beat");
    step(0, 1, 0, NONE, NONE, "R3 beat");
    step(0, 0, 1, SHORT, SHORT, "R3 end with two beats");
    step(0, 1, 0, NONE, NONE, "R8 beat after verdict");
    step(0, 0, 1, NONE, NONE, "R8 end after verdict");
  endtask

  task automatic t_surplus();
    step(1, 0, 0, NONE, NONE, "R4 open");
    for (int i = 0; i < 4; i++) step(0, 1, 0, NONE, NONE, "R4 beat");
    step(0, 1, 0, LONG, LONG, "R4 fifth beat");
    step(0, 0, 1, NONE, NONE, "R8 end after surplus");
  endtask

  task automatic t_coincident();
    step(1, 0, 0, NONE, NONE, "R7 open");
    for (int i = 0; i < 3; i++) step(0, 1, 0, NONE, NONE, "R7 beat");
    step(0, 1, 1, OK, LATE, "R7 final beat with end");
    step(1, 0, 0, NONE, NONE, "R7 open");
    for (int i = 0; i < 4; i++) step(0, 1, 0, NONE, NONE, "R7 beat");
    step(0, 1, 1, LONG, LONG, "R7 surplus beat with end");
  endtask

  task automatic t_held_start();
    step(1, 0, 0, NONE, NONE, "R8 open held");
    for (int i = 0; i < 4; i++) step(1, 1, 0, NONE, NONE, "R8 beat held");
    step(1, 0, 1, OK, OK, "R8 end held");
    step(1, 0, 1, NONE, NONE, "R8 held start no reopen");
    step(0, 0, 0, NONE, NONE, "R8 start low");
    step(1, 0, 0, NONE, NONE, "R8 fresh edge");
    step(0, 0, 1, SHORT, SHORT, "R8 reopened burst closes short");
  endtask

  task automatic t_edge_in_burst();
    step(1, 0, 0, NONE, NONE, "R8 open");
    step(0, 1, 0, NONE, NONE, "R8 beat");
    step(0, 1, 0, NONE, NONE, "R8 beat");
    step(1, 1, 0, NONE, NONE, "R8 edge during burst");
    step(0, 1, 0, NONE, NONE, "R8 beat");
    step(0, 0, 1, OK, OK, "R8 count kept across edge");
  endtask

  task automatic t_reset_mid_burst();
    step(1, 0, 0, NONE, NONE, "R9 open");
    step(0, 1, 0, NONE, NONE, "R9 beat");
    step(0, 1, 0, NONE, NONE, "R9 beat");
    @(negedge clk);
    rst_n = 1'b0; beat = 1'b0; burst_end = 1'b1; burst_start = 1'b0;
    @(posedge clk);
    #1;
    judge("R9 end during reset", "relaxed", observe(err_l, cause_l, ok_l), NONE);
    judge("R9 end during reset", "strict",  observe(err_t, cause_t, ok_t), NONE);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1, NONE, NONE, "R9 burst discarded");
    step(1, 0, 0, NONE, NONE, "R9 open after reset");
    for (int i = 0; i < 4; i++) step(0, 1, 0, NONE, NONE, "R9 beat");
    step(0, 0, 1, OK, OK, "R9 clean burst after reset");
  endtask

  initial begin
    t_reset();
    t_idle_inputs();
    t_gap_before_end();
    t_strict_exact();
    t_short();
    t_surplus();
    t_coincident();
    t_held_start();
    t_edge_in_burst();
    t_reset_mid_burst();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule